// File: doc/BRIEF.md
# Runtime-Programmable Two-Plane Logic Array

This block evaluates a sum-of-products network whose structure is held in registers and rewritten while the chip runs. Four inputs feed sixteen product terms. Each term's AND-plane row chooses, for every input, whether the plain literal, the inverted literal or neither takes part. Each term's OR-plane row then chooses which of the four outputs that term drives. The outputs are combinational functions of the inputs and the stored personality.

In general mode one product term may feed any number of outputs, so terms common to several functions are built once. With `pal_mode` high the OR plane takes a fixed topology: output k can only gather terms 4k to 4k+3. Any connection bit that points outside that group is disregarded. Connection bits inside the group still apply. One personality row is written per clock through a term-addressed write port, and reset empties the whole personality.

A typical use loads a small code converter, such as a BCD-to-Gray mapping, and switches to the grouped topology when every output's terms fit in its own group.

Top module: `pla_array`

## Requirements
- R1: A synchronous active-high `rst` clears every AND-plane and OR-plane bit. From the cycle after reset, every output reads 0 for every input value.
- R2: With `cfg_we` high at a rising edge, the AND row `cfg_and` and the OR row `cfg_or` are stored for term `cfg_term`. The outputs show the new personality after that edge and not before it.
- R3: Input i is controlled by AND-row bits [2i+1:2i]. Code 00 leaves the input out of the term. Code 01 requires the input to be 0. Code 10 requires the input to be 1.
- R4: AND-row code 11 on any input forces the term to 0 for every input value.
- R5: A term whose AND row is all 00 evaluates to 1.
- R6: OR-row bit k connects the term to output k. An output with no connected term, or whose connected terms are all 0, reads 0.
- R7: In general mode (`pal_mode` = 0) one term drives every output whose OR bit is set in that term's row.
- R8: In grouped mode (`pal_mode` = 1), output k is the OR of terms 4k to 4k+3 whose bit k is set. OR bits that connect a term outside that group are ignored.
- R9: Loaded with W = A + BD + BC, X = BC', Y = B + C and Z = A'B'C'D + BCD + AD' + B'CD' (A = in_vec[3] through D = in_vec[0]; W = out_vec[3] through Z = out_vec[0]), the array gives those values for inputs 0 to 9 in both modes.
- R10: For any stored personality and any of the 16 input values, each output equals the sum-of-products defined by R3 to R8 for the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Personality write enable |
| cfg_term | input | 4 | Term index to write |
| cfg_and | input | 8 | AND-plane row, 2 bits per input |
| cfg_or | input | 4 | OR-plane row, 1 bit per output |
| pal_mode | input | 1 | 1 selects the fixed group-of-four OR topology |
| in_vec | input | 4 | Logic inputs |
| out_vec | output | 4 | Logic outputs |

## Verification
The bench uses the default parameters: 4 inputs, 16 terms and 4 outputs, which gives groups of four terms per output. At this size every input value can be applied against every personality, so each function is compared over its whole truth table. Term indices 0 to 15 cover all four groups, which lets connections across groups be tested for being ignored in grouped mode.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    LIT_SKIP = 2'b00,
    LIT_NEG  = 2'b01,
    LIT_POS  = 2'b10,
    LIT_KILL = 2'b11
  } lit_code_e;
endpackage

// File: rtl/pla_pers_store.sv
module pla_pers_store #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  localparam int AW    = $clog2(N_TERM),
  localparam int ROW_W = 2 * N_IN
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [AW-1:0]                     wr_idx,
  input  logic [ROW_W-1:0]                  wr_and,
  input  logic [N_OUT-1:0]                  wr_or,
  output logic [N_TERM-1:0][ROW_W-1:0]      and_rows,
  output logic [N_TERM-1:0][N_OUT-1:0]      or_rows
);
  always_ff @(posedge clk) begin
    if (rst) begin
      and_rows <= '0;
      or_rows  <= '0;
    end else if (wr_en) begin
      and_rows[wr_idx] <= wr_and;
      or_rows[wr_idx]  <= wr_or;
    end
  end

  // R2: a write lands in the addressed row one edge later
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (and_rows[$past(wr_idx)] == $past(wr_and)) &&
              (or_rows[$past(wr_idx)]  == $past(wr_or)));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 16,
  localparam int ROW_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]               in_vec,
  input  logic [N_TERM-1:0][ROW_W-1:0]  and_rows,
  output logic [N_TERM-1:0]             term_vec
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] lit_ok;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      always_comb begin
        case (lit_code_e'(and_rows[t][2*i +: 2]))
          LIT_SKIP: lit_ok[i] = 1'b1;
          LIT_NEG:  lit_ok[i] = ~in_vec[i];
          LIT_POS:  lit_ok[i] = in_vec[i];
          default:  lit_ok[i] = 1'b0;
        endcase
      end
    end
    assign term_vec[t] = &lit_ok;
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  localparam int GRP   = N_TERM / N_OUT
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           pal_mode,
  input  logic [N_TERM-1:0]              term_vec,
  input  logic [N_TERM-1:0][N_OUT-1:0]   or_rows,
  output logic [N_OUT-1:0]               out_vec
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [N_TERM-1:0] link;
    for (genvar t = 0; t < N_TERM; t++) begin : g_link
      if ((t / GRP) == k) begin : g_own
        assign link[t] = or_rows[t][k];
      end else begin : g_other
        assign link[t] = or_rows[t][k] & ~pal_mode;
      end
    end
    assign out_vec[k] = |(link & term_vec);

    // R8: in grouped mode a high output needs a live term in its own group
    p_pal_group_r8: assert property (@(posedge clk) disable iff (rst)
      (pal_mode && out_vec[k]) |-> (|term_vec[k*GRP +: GRP]));
    // R6: no live term anywhere means the output stays low
    p_no_term_low_r6: assert property (@(posedge clk) disable iff (rst)
      (term_vec == '0) |-> !out_vec[k]);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  localparam int AW    = $clog2(N_TERM),
  localparam int ROW_W = 2 * N_IN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_term,
  input  logic [ROW_W-1:0]  cfg_and,
  input  logic [N_OUT-1:0]  cfg_or,
  input  logic              pal_mode,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  out_vec
);
  logic [N_TERM-1:0][ROW_W-1:0] and_rows;
  logic [N_TERM-1:0][N_OUT-1:0] or_rows;
  logic [N_TERM-1:0]            term_vec;

  pla_pers_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_store (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_idx(cfg_term),
    .wr_and(cfg_and), .wr_or(cfg_or), .and_rows(and_rows), .or_rows(or_rows));

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_vec(in_vec), .and_rows(and_rows), .term_vec(term_vec));

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .clk(clk), .rst(rst), .pal_mode(pal_mode), .term_vec(term_vec),
    .or_rows(or_rows), .out_vec(out_vec));

  // R1: once reset has been applied every output reads low
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (out_vec == '0));
endmodule

// File: tb/pla_array_tb_top.sv
`timescale 1ns/100ps
module pla_array_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_term = '0;
  logic [7:0] cfg_and = '0;
  logic [3:0] cfg_or = '0;
  logic       pal_mode = 1'b0;
  logic [3:0] in_vec = '0;
  logic [3:0] out_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] m_and [16];
  logic [3:0] m_or  [16];

  always #2.5 clk = ~clk;

  pla_array dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_term(cfg_term),
    .cfg_and(cfg_and), .cfg_or(cfg_or), .pal_mode(pal_mode),
    .in_vec(in_vec), .out_vec(out_vec));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s in=%0d pal=%0b actual=%b expected=%b", req, in_vec, pal_mode, act, exp);
    end
  endtask

  function automatic logic [7:0] lit(input int idx, input logic [1:0] code);
    logic [7:0] r = '0;
    r[2*idx +: 2] = code;
    return r;
  endfunction

  function automatic logic [3:0] model(input logic [3:0] x, input logic pal);
    logic [3:0] r = '0;
    for (int t = 0; t < 16; t++) begin
      logic term = 1'b1;
      for (int i = 0; i < 4; i++) begin
        case (m_and[t][2*i +: 2])
          2'b01: if (x[i]) term = 1'b0;
          2'b10: if (!x[i]) term = 1'b0;
          2'b11: term = 1'b0;
          default: ;
        endcase
      end
      for (int k = 0; k < 4; k++)
        if (term && m_or[t][k] && (!pal || (t / 4) == k)) r[k] = 1'b1;
    end
    return r;
  endfunction

  task automatic prog(input int t, input logic [7:0] a, input logic [3:0] o);
    @(negedge clk);
    cfg_we = 1'b1; cfg_term = 4'(t); cfg_and = a; cfg_or = o;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_and[t] = a; m_or[t] = o;
  endtask

  task automatic clear_all();
    for (int t = 0; t < 16; t++) prog(t, 8'h00, 4'h0);
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 16; v++) begin
      in_vec = 4'(v); #1;
      chk(req, out_vec, model(in_vec, pal_mode));
    end
  endtask

  task automatic t_reset();
    for (int t = 0; t < 16; t++) begin m_and[t] = '0; m_or[t] = '0; end
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    for (int v = 0; v < 16; v++) begin
      in_vec = 4'(v); #1;
      chk("R1 reset", out_vec, 4'h0);
      chk("R6 unconnected", out_vec, 4'h0);
    end
  endtask

  task automatic t_write_timing();
    // R5: term 5 with all-absent literals on output 0
    in_vec = 4'h9;
    @(negedge clk);
    cfg_we = 1'b1; cfg_term = 4'd5; cfg_and = 8'h00; cfg_or = 4'b0001;
    #1 chk("R2 before edge", out_vec, 4'h0);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_and[5] = 8'h00; m_or[5] = 4'b0001;
    chk("R2 after edge", out_vec, 4'b0001);
    for (int v = 0; v < 16; v++) begin
      in_vec = 4'(v); #1;
      chk("R5 empty term", out_vec, 4'b0001);
    end
  endtask

  task automatic t_literals();
    clear_all();
    // R3: input 2 true, input 0 complemented, output 1
    prog(0, lit(2, 2'b10) | lit(0, 2'b01), 4'b0010);
    for (int v = 0; v < 16; v++) begin
      in_vec = 4'(v); #1;
      chk("R3 literal codes", out_vec, {2'b00, in_vec[2] & ~in_vec[0], 1'b0});
    end
    // R4: a kill code on input 3 drops the term
    prog(0, lit(2, 2'b10) | lit(0, 2'b01) | lit(3, 2'b11), 4'b0010);
    for (int v = 0; v < 16; v++) begin
      in_vec = 4'(v); #1;
      chk("R4 kill code", out_vec, 4'h0);
    end
  endtask

  task automatic t_share();
    clear_all();
    pal_mode = 1'b0;
    prog(6, lit(1, 2'b10) | lit(3, 2'b01), 4'b1111);
    for (int v = 0; v < 16; v++) begin
      in_vec = 4'(v); #1;
      chk("R7 shared term", out_vec, {4{in_vec[1] & ~in_vec[3]}});
    end
  endtask

  task automatic t_pal();
    clear_all();
    prog(1, lit(0, 2'b10), 4'b1001);   // own group of output 0, also points at 3
    prog(13, lit(1, 2'b10), 4'b1000);  // own group of output 3
    for (int m = 0; m < 2; m++) begin
      pal_mode = 1'(m);
      for (int v = 0; v < 16; v++) begin
        in_vec = 4'(v); #1;
        if (m == 0) chk("R8 general ref", out_vec, {in_vec[0] | in_vec[1], 2'b00, in_vec[0]});
        else        chk("R8 group only", out_vec, {in_vec[1], 2'b00, in_vec[0]});
      end
    end
    pal_mode = 1'b0;
  endtask

  task automatic t_bcd();
    clear_all();
    prog(0,  lit(3,2'b01)|lit(2,2'b01)|lit(1,2'b01)|lit(0,2'b10), 4'b0001);
    prog(1,  lit(2,2'b10)|lit(1,2'b10)|lit(0,2'b10), 4'b0001);
    prog(2,  lit(3,2'b10)|lit(0,2'b01), 4'b0001);
    prog(3,  lit(2,2'b01)|lit(1,2'b10)|lit(0,2'b01), 4'b0001);
    prog(4,  lit(2,2'b10), 4'b0010);
    prog(5,  lit(1,2'b10), 4'b0010);
    prog(8,  lit(2,2'b10)|lit(1,2'b01), 4'b0100);
    prog(12, lit(3,2'b10), 4'b1000);
    prog(13, lit(2,2'b10)|lit(0,2'b10), 4'b1000);
    prog(14, lit(2,2'b10)|lit(1,2'b10), 4'b1000);
    for (int m = 0; m < 2; m++) begin
      pal_mode = 1'(m);
      for (int v = 0; v < 10; v++) begin
        logic a, b, c, d;
        logic [3:0] e;
        in_vec = 4'(v); #1;
        {a, b, c, d} = in_vec;
        e[3] = a | (b & d) | (b & c);
        e[2] = b & ~c;
        e[1] = b | c;
        e[0] = (~a & ~b & ~c & d) | (b & c & d) | (a & ~d) | (~b & c & ~d);
        chk("R9 bcd converter", out_vec, e);
      end
    end
    pal_mode = 1'b0;
  endtask

  task automatic t_random();
    for (int p = 0; p < 6; p++) begin
      for (int t = 0; t < 16; t++) prog(t, 8'($urandom), 4'($urandom));
      pal_mode = 1'b0; sweep("R10 random general");
      pal_mode = 1'b1; sweep("R10 random grouped");
    end
    pal_mode = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    t_reset();
    t_write_timing();
    t_literals();
    t_share();
    t_pal();
    t_bcd();
    t_random();
    finish_run();
  end
endmodule